// File: doc/BRIEF.md
# Request-Response Latency Monitor

This block watches a transaction interface where each request carries a small tag (ID) and each response returns the same tag. Responses need not come back in request order. For every completed transaction the monitor reports the number of clock cycles between the cycle in which the request was presented and the cycle in which its response was presented. It also counts how many transactions fell into a short, a medium and a long latency band, plus an overflow band.

A single free-running timestamp counter serves all transactions. When a request is seen, the current timestamp is written into a memory addressed by the request ID, and a per-ID outstanding flag is set. When a response is seen, the stored timestamp for that ID is read back and subtracted from the timestamp captured with the response. The subtraction is modulo the timestamp width, so counter wrap-around does not disturb the result. A response whose ID has no outstanding request raises a one-cycle error pulse instead of a measurement.

Top module: `lat_mon`

## Requirements
- R1: After a synchronous active-high reset, all four band counters read 0, `lat_valid` and `orphan_err` are 0, and no ID is outstanding. A response to an ID requested before the reset is treated as orphaned.
- R2: A response presented at clock edge k (with `rsp_valid` high) produces exactly one one-cycle pulse, either on `lat_valid` or on `orphan_err`, visible after edge k+1.
- R3: The reported latency is the response edge number minus the edge number of the request with the same ID. Responses may complete in any order relative to requests.
- R4: `lat_value` is that difference modulo 2^TS_W, and it stays correct across wrap-around of the timestamp counter.
- R5: Each measured latency increments exactly one band counter: `cnt_short` for 0..10, `cnt_medium` for 11..100, `cnt_long` for 101..1000, and `cnt_over` for anything above 1000.
- R6: Each band counter saturates at 2^CNT_W-1 and holds there on further hits.
- R7: A response to an ID that is not outstanding pulses `orphan_err`, does not pulse `lat_valid`, and leaves every band counter unchanged.
- R8: A response and a request on the same ID in the same cycle complete the old transaction using the old timestamp, and start a new one with the current timestamp. The ID stays outstanding.
- R9: A response clears its ID's outstanding flag, so a second response to the same ID without a new request is orphaned.
- R10: In cycles with no response two edges earlier, `lat_valid` and `orphan_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | ID_W | Tag of the request |
| rsp_valid | input | 1 | A response is presented this cycle |
| rsp_id | input | ID_W | Tag of the response |
| lat_valid | output | 1 | One-cycle strobe: `lat_value` holds a new measurement |
| lat_value | output | TS_W | Measured latency in cycles, modulo 2^TS_W |
| orphan_err | output | 1 | One-cycle pulse: response without an outstanding request |
| cnt_short | output | CNT_W | Saturating count of latencies 0..10 |
| cnt_medium | output | CNT_W | Saturating count of latencies 11..100 |
| cnt_long | output | CNT_W | Saturating count of latencies 101..1000 |
| cnt_over | output | CNT_W | Saturating count of latencies above 1000 |

## Verification
A request and a response can land in the same cycle. In that case the timestamp memory is written and read at the same edge, and the outstanding flags are set and cleared at the same edge. The bench provokes this case in two forms. In the first, the two sides carry different IDs. In the second, they carry the same ID, and a later response on that ID must then show a latency measured from the second request, not the first. The bench's reference model processes the response before the request within a cycle. The DUT's measurement, its error pulse and its band counts are compared against that model two edges later.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;

  // Latency band selected for one measurement; the value indexes the counters.
  typedef enum logic [1:0] {
    BIN_SHORT = 2'd0,
    BIN_MED   = 2'd1,
    BIN_LONG  = 2'd2,
    BIN_OVER  = 2'd3
  } lat_bin_e;

  localparam int NUM_BINS = 4;

endpackage

// File: rtl/lat_sat_counter.sv
module lat_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + ONE;
    end
  end

  // once full, a counter never moves off its ceiling until reset
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP)); // R6

endmodule

// File: rtl/lat_ts_table.sv
module lat_ts_table #(
  parameter int ID_W = 4,
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_id,
  input  logic [TS_W-1:0] wr_ts,
  input  logic            rd_en,
  input  logic [ID_W-1:0] rd_id,
  output logic [TS_W-1:0] rd_ts,
  output logic            rd_hit
);

  localparam int DEPTH = 1 << ID_W;

  // Timestamp storage: one write port, one registered read port, no reset,
  // read-before-write on a same-address collision.
  logic [TS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_id] <= wr_ts;
    end
    if (rd_en) begin
      rd_ts <= mem[rd_id];
    end
  end

  // Outstanding flags, one register per ID; a set beats a clear.
  logic [DEPTH-1:0] busy;

  for (genvar g = 0; g < DEPTH; g++) begin : g_busy
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
      end else if (wr_en && (wr_id == ID_W'(g))) begin
        flag_q <= 1'b1;
      end else if (rd_en && (rd_id == ID_W'(g))) begin
        flag_q <= 1'b0;
      end
    end
    assign busy[g] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit <= 1'b0;
    end else begin
      rd_hit <= rd_en && busy[rd_id];
    end
  end

  AST_SET_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy[$past(wr_id)]); // R8

  AST_CLEAR_ON_RSP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && (wr_id == rd_id))) |=> !busy[$past(rd_id)]); // R9

endmodule

// File: rtl/lat_binner.sv
module lat_binner
  import lat_mon_pkg::*;
#(
  parameter int LAT_W     = 16,
  parameter int CNT_W     = 16,
  parameter int SHORT_MAX = 10,
  parameter int MED_MAX   = 100,
  parameter int LONG_MAX  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [LAT_W-1:0] in_lat,
  output logic [CNT_W-1:0] cnt_short,
  output logic [CNT_W-1:0] cnt_med,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_over
);

  localparam logic [LAT_W-1:0] SHORT_LIM = LAT_W'(SHORT_MAX);
  localparam logic [LAT_W-1:0] MED_LIM   = LAT_W'(MED_MAX);
  localparam logic [LAT_W-1:0] LONG_LIM  = LAT_W'(LONG_MAX);

  function automatic lat_bin_e classify(input logic [LAT_W-1:0] v);
    if (v <= SHORT_LIM)     return BIN_SHORT;
    else if (v <= MED_LIM)  return BIN_MED;
    else if (v <= LONG_LIM) return BIN_LONG;
    else                    return BIN_OVER;
  endfunction

  lat_bin_e           bin_sel;
  logic [NUM_BINS-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_BINS];

  assign bin_sel = classify(in_lat);

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    assign inc[g] = in_valid && (bin_sel == lat_bin_e'(g));
    lat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc[g]),
      .count (cnt[g])
    );
  end

  assign cnt_short = cnt[BIN_SHORT];
  assign cnt_med   = cnt[BIN_MED];
  assign cnt_long  = cnt[BIN_LONG];
  assign cnt_over  = cnt[BIN_OVER];

  AST_ONE_BAND: assert property (@(posedge clk) disable iff (rst)
    $countones({cnt[0] != $past(cnt[0]), cnt[1] != $past(cnt[1]),
                cnt[2] != $past(cnt[2]), cnt[3] != $past(cnt[3])}) <= 1); // R5

  AST_BAND_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    ((cnt[0] != $past(cnt[0])) || (cnt[1] != $past(cnt[1])) ||
     (cnt[2] != $past(cnt[2])) || (cnt[3] != $past(cnt[3]))) |-> $past(in_valid)); // R7

endmodule

// File: rtl/lat_mon.sv
module lat_mon #(
  parameter int ID_W      = 4,
  parameter int TS_W      = 16,
  parameter int CNT_W     = 16,
  parameter int SHORT_MAX = 10,
  parameter int MED_MAX   = 100,
  parameter int LONG_MAX  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ID_W-1:0]  req_id,
  input  logic             rsp_valid,
  input  logic [ID_W-1:0]  rsp_id,
  output logic             lat_valid,
  output logic [TS_W-1:0]  lat_value,
  output logic             orphan_err,
  output logic [CNT_W-1:0] cnt_short,
  output logic [CNT_W-1:0] cnt_medium,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_over
);

  localparam logic [TS_W-1:0] TS_ONE = {{(TS_W-1){1'b0}}, 1'b1};

  // shared free-running timestamp
  logic [TS_W-1:0] ts_q;
  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else     ts_q <= ts_q + TS_ONE;
  end

  // stage 1: table read in flight, response timestamp captured alongside
  logic            s1_pend;
  logic [TS_W-1:0] s1_now;
  logic [TS_W-1:0] s1_then;
  logic            s1_hit;

  always_ff @(posedge clk) begin
    if (rst) s1_pend <= 1'b0;
    else     s1_pend <= rsp_valid;
  end

  always_ff @(posedge clk) begin
    s1_now <= ts_q;
  end

  lat_ts_table #(.ID_W(ID_W), .TS_W(TS_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (req_valid),
    .wr_id  (req_id),
    .wr_ts  (ts_q),
    .rd_en  (rsp_valid),
    .rd_id  (rsp_id),
    .rd_ts  (s1_then),
    .rd_hit (s1_hit)
  );

  // modular difference absorbs timestamp wrap
  logic [TS_W-1:0] s1_lat;
  logic            s1_done;
  logic            s1_orphan;
  assign s1_lat    = s1_now - s1_then;
  assign s1_done   = s1_pend && s1_hit;
  assign s1_orphan = s1_pend && !s1_hit;

  // stage 2: registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_valid  <= 1'b0;
      orphan_err <= 1'b0;
      lat_value  <= '0;
    end else begin
      lat_valid  <= s1_done;
      orphan_err <= s1_orphan;
      if (s1_done) lat_value <= s1_lat;
    end
  end

  lat_binner #(
    .LAT_W     (TS_W),
    .CNT_W     (CNT_W),
    .SHORT_MAX (SHORT_MAX),
    .MED_MAX   (MED_MAX),
    .LONG_MAX  (LONG_MAX)
  ) u_binner (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_done),
    .in_lat    (s1_lat),
    .cnt_short (cnt_short),
    .cnt_med   (cnt_medium),
    .cnt_long  (cnt_long),
    .cnt_over  (cnt_over)
  );

  AST_RSP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> ##1 (lat_valid || orphan_err)); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (lat_valid || orphan_err) |-> $past(rsp_valid, 2)); // R10

  AST_ORPHAN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lat_valid && orphan_err)); // R7

endmodule

// File: tb/lat_mon_tb_top.sv
module lat_mon_tb_top;

  localparam int ID_W   = 4;
  localparam int TS_W   = 11;
  localparam int CNT_W  = 5;
  localparam int NID    = 1 << ID_W;
  localparam int TS_MOD = 1 << TS_W;
  localparam int SAT    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, rsp_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0, rsp_id = '0;
  logic lat_valid, orphan_err;
  logic [TS_W-1:0] lat_value;
  logic [CNT_W-1:0] cnt_short, cnt_medium, cnt_long, cnt_over;

  always #4 clk = ~clk;  // 125 MHz

  lat_mon #(.ID_W(ID_W), .TS_W(TS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .lat_valid(lat_valid), .lat_value(lat_value), .orphan_err(orphan_err),
    .cnt_short(cnt_short), .cnt_medium(cnt_medium),
    .cnt_long(cnt_long), .cnt_over(cnt_over)
  );

  int checks = 0;
  int failures = 0;
  int edge_no = 0;
  int wd = 0;

  always @(posedge clk) begin
    edge_no <= edge_no + 1;
    wd <= wd + 1;
    if (wd > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // reference model
  bit m_out [NID];
  int m_ts  [NID];
  int m_cnt [4];

  typedef struct {
    bit    rsp;
    bit    hit;
    int    lat;
    int    c0, c1, c2, c3;
    string tag;
  } exp_t;

  exp_t p0, p1;

  function automatic exp_t idle_exp(input string tag);
    exp_t e;
    e.rsp = 0; e.hit = 0; e.lat = 0;
    e.c0 = m_cnt[0]; e.c1 = m_cnt[1]; e.c2 = m_cnt[2]; e.c3 = m_cnt[3];
    e.tag = tag;
    return e;
  endfunction

  function automatic int band(input int lat);
    if (lat <= 10)        return 0;
    else if (lat <= 100)  return 1;
    else if (lat <= 1000) return 2;
    else                  return 3;
  endfunction

  task automatic check_exp(input exp_t e);
    bit ok;
    int want_lat;
    want_lat = e.lat % TS_MOD;
    if (e.rsp && e.hit) ok = lat_valid && !orphan_err && (int'(lat_value) == want_lat);
    else if (e.rsp)     ok = !lat_valid && orphan_err;
    else                ok = !lat_valid && !orphan_err;
    ok = ok && (int'(cnt_short) == e.c0) && (int'(cnt_medium) == e.c1)
            && (int'(cnt_long) == e.c2) && (int'(cnt_over) == e.c3);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual v=%0b err=%0b lat=%0d cnt=%0d/%0d/%0d/%0d expected rsp=%0b hit=%0b lat=%0d cnt=%0d/%0d/%0d/%0d",
               e.tag, lat_valid, orphan_err, lat_value, cnt_short, cnt_medium, cnt_long, cnt_over,
               e.rsp, e.hit, want_lat, e.c0, e.c1, e.c2, e.c3);
    end
  endtask

  // One cycle: called at a negedge, drives inputs for the next edge.
  task automatic step(input bit rv, input int rid, input bit sv, input int sid, input string tag);
    exp_t e;
    int this_edge;
    check_exp(p1);
    p1 = p0;
    this_edge = edge_no + 1;
    e = idle_exp(tag);
    e.rsp = sv;
    if (sv) begin
      if (m_out[sid]) begin
        e.hit = 1;
        e.lat = this_edge - m_ts[sid];
        m_out[sid] = 0;
        if (m_cnt[band(e.lat)] < SAT) m_cnt[band(e.lat)]++;
      end
    end
    if (rv) begin
      m_out[rid] = 1;
      m_ts[rid] = this_edge;
    end
    e.c0 = m_cnt[0]; e.c1 = m_cnt[1]; e.c2 = m_cnt[2]; e.c3 = m_cnt[3];
    p0 = e;
    req_valid = rv; req_id = ID_W'(rid);
    rsp_valid = sv; rsp_id = ID_W'(sid);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask

  // request on id, then a response exactly lat edges later
  task automatic txn(input int id, input int lat, input string tag);
    step(1, id, 0, 0, tag);
    idle(lat - 1, tag);
    step(0, 0, 1, id, tag);
  endtask

  task automatic do_reset();
    rst = 1;
    req_valid = 0; rsp_valid = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NID; i++) m_out[i] = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    p0 = idle_exp("R1");
    p1 = idle_exp("R1");
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R1: reset state
    idle(3, "R1");

    // R2 / R3: simple measurement
    txn(3, 6, "R2");
    idle(2, "R2");

    // R5: band boundaries, also crossing the 2^TS_W wrap (R4)
    txn(1, 10, "R5");
    txn(2, 11, "R5");
    txn(3, 100, "R5");
    txn(4, 101, "R5");
    txn(5, 1000, "R5");
    txn(6, 1001, "R5");
    idle(2, "R5");

    // R4: a run of long transactions spanning several wraps
    for (int i = 0; i < 4; i++) txn(i, 700 + i * 37, "R4");
    idle(2, "R4");

    // R3: out-of-order completion
    step(1, 1, 0, 0, "R3");
    step(1, 2, 0, 0, "R3");
    step(1, 3, 0, 0, "R3");
    idle(4, "R3");
    step(0, 0, 1, 3, "R3");
    step(0, 0, 1, 1, "R3");
    idle(2, "R3");
    step(0, 0, 1, 2, "R3");
    idle(2, "R3");

    // R7: orphan response
    step(0, 0, 1, 9, "R7");
    idle(2, "R7");

    // R9: double response
    txn(8, 3, "R9");
    step(0, 0, 1, 8, "R9");
    idle(2, "R9");

    // R8: same-cycle request and response, same ID then different IDs
    step(1, 5, 0, 0, "R8");
    idle(4, "R8");
    step(1, 5, 1, 5, "R8");
    idle(6, "R8");
    step(0, 0, 1, 5, "R8");
    step(1, 11, 0, 0, "R8");
    idle(2, "R8");
    step(1, 12, 1, 11, "R8");
    idle(3, "R8");
    step(0, 0, 1, 12, "R8");
    idle(2, "R8");

    // R1: reset while an ID is outstanding
    step(1, 7, 0, 0, "R1");
    idle(2, "R1");
    do_reset();
    idle(2, "R1");
    step(0, 0, 1, 7, "R1");
    idle(2, "R1");

    // R6: saturate the short band and keep hitting it
    for (int i = 0; i < SAT + 8; i++) txn(i % NID, 1 + (i % 5), "R6");
    idle(2, "R6");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit rv, sv;
      int rid, sid, forced;
      rv = 0; sv = 0; rid = 0; sid = 0; forced = -1;
      for (int k = 0; k < NID; k++)
        if (m_out[k] && (edge_no + 1 - m_ts[k]) > 1500) forced = k;
      if (forced >= 0) begin
        sv = 1; sid = forced;
      end else if ($urandom_range(99) < 45) begin
        int start;
        start = $urandom_range(NID - 1);
        for (int k = 0; k < NID; k++)
          if (!sv && m_out[(start + k) % NID]) begin sv = 1; sid = (start + k) % NID; end
      end else if ($urandom_range(99) < 4) begin
        sv = 1; sid = $urandom_range(NID - 1);
      end
      if ($urandom_range(99) < 40) begin
        int start;
        start = $urandom_range(NID - 1);
        for (int k = 0; k < NID; k++)
          if (!rv && (!m_out[(start + k) % NID] || (sv && sid == (start + k) % NID))) begin
            rv = 1; rid = (start + k) % NID;
          end
      end
      step(rv, rid, sv, sid, "R3");
    end
    idle(3, "R10");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule